// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block sits between a pulse-width command and the two gate drivers of a synchronous buck half-bridge. It reads three comparator flags that classify the PWM pin as high, low or mid-level. It then steps a sequencer that drives the high-side and low-side gate enables and never asserts both at once. When the high side turns off, the low side does not come on after a fixed dead time. It comes on a set number of cycles after the switch node is sensed below 1 V, or after the high-side gate is sensed discharged, whichever comes first. If neither flag appears within a bounded wait, the low side stays off and a timeout status is raised.

Several inputs can override the command. A mid-level PWM input held long enough parks both gates. An active-low disable input, filtered over a few cycles in both directions, holds both gates off. A bias undervoltage flag forces both gates off at once. A bootstrap undervoltage flag blocks high-side turn-on. An active-low skip input masks the low-side gate while the high side keeps switching. All delays are clock-cycle counts set by parameters.

Every sensing and comparator input is assumed to be synchronous to `clk`. The undervoltage hysteresis is applied in the analog comparator that produces `bias_uv`. A floating disable pin is resolved low before it reaches `dis_n`, and a floating skip pin is resolved high before it reaches `skip_n`.

Top module: `gate_dt_ctrl`

## Requirements
- R1: From the all-off state, a high PWM command asserts `gh_en` exactly HS_ON_DLY+2 cycles after the input changes, and `gl_en` stays low. When the low side is on and PWM goes high, `gl_en` drops LS_OFF_DLY+2 cycles after the change, and `gh_en` rises HS_ON_DLY cycles after that.
- R2: When PWM goes low while the high side is on, `gh_en` drops HS_OFF_DLY+2 cycles after the change. If `sw_low` is already asserted, `gl_en` rises LS_ON_DLY+1 cycles after `gh_en` drops.
- R3: With `sw_low` held low, an asserted `hsg_low` alone starts the same low-side delay and turns the low side on.
- R4: `gh_en` and `gl_en` are never both high. Either enable rises only when the other was low in the previous cycle.
- R5: A mid-level PWM held for TRI_HOLD consecutive cycles parks both gates, with state code 0. A shorter mid-level excursion has no effect on the gates. After parking, a low command turns the low side on LS_ON_DLY+2 cycles after the change, without waiting for a sensing flag.
- R6: `dis_n` low for DIS_DLY consecutive cycles turns both gates off, DIS_DLY+1 cycles after the change. A shorter low pulse is ignored. After a return high, the high side comes back on DIS_DLY+1+HS_ON_DLY cycles after the change.
- R7: While `skip_n` is low, `gl_en` is low from the next cycle on, the state sequence continues, and the high side keeps operating. When `skip_n` returns high in the low-side-on state, `gl_en` rises on the next cycle.
- R8: `bias_uv` drives both gates low on the next clock edge and resets the sequencer to state 0. After release, a pending high command turns the high side on HS_ON_DLY+1 cycles later.
- R9: `gh_en` never rises in a cycle after `boot_uv` was high. Once `boot_uv` clears, a pending high command asserts `gh_en` HS_ON_DLY+1 cycles later.
- R10: If neither sensing flag arrives within MAX_WAIT cycles after the high side turns off, the sequencer enters the stall state with state code 8. In that state `timeout_o` is high and `gl_en` stays low, even if a flag arrives later. A later high command clears the stall.
- R11: `state_o` reports the sequencer state with these codes: 0 off, 1 high-side delay, 2 high-side on, 3 high-side turn-off, 4 sensing, 5 low-side delay, 6 low-side on, 7 low-side turn-off, 8 stall. After reset it reads 0 with both gates low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_above_hi | input | 1 | PWM pin above the high threshold |
| pwm_below_lo | input | 1 | PWM pin below the low threshold |
| pwm_in_mid | input | 1 | PWM pin inside the mid-level window |
| dis_n | input | 1 | Active-low disable |
| skip_n | input | 1 | Active-low low-side skip |
| bias_uv | input | 1 | Bias supply undervoltage |
| boot_uv | input | 1 | Bootstrap supply undervoltage |
| sw_low | input | 1 | Switch node below 1 V |
| hsg_low | input | 1 | High-side gate below 1 V |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |
| state_o | output | 4 | Sequencer state code |
| timeout_o | output | 1 | Sensing timeout (stall) status |

## Verification
On every cycle, the assertions check the safety behaviour: the two enables never overlap, neither enable rises unless the other was low, bias undervoltage clears both gates on the next edge, skip masks the low side, bootstrap undervoltage blocks high-side turn-on, and the low side stays off while the timeout is flagged. The bench scenarios are the only place where the cycle counts of each delay are pinned down. The scenarios also show that short mid-level and disable glitches are filtered out, and they show the choice between the switch-node flag and the gate-discharge flag. Finally, they cover recovery from parking, disable, undervoltage and the stall.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [3:0] {
        ST_OFF     = 4'd0,
        ST_HS_DLY  = 4'd1,
        ST_HS_ON   = 4'd2,
        ST_HS_FALL = 4'd3,
        ST_SENSE   = 4'd4,
        ST_LS_DLY  = 4'd5,
        ST_LS_ON   = 4'd6,
        ST_LS_FALL = 4'd7,
        ST_STALL   = 4'd8
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_PARK = 2'd0,
        CMD_HI   = 2'd1,
        CMD_LO   = 2'd2
    } pwm_cmd_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic hs_drives(input seq_state_e s);
        return (s == ST_HS_ON) || (s == ST_HS_FALL);
    endfunction

    function automatic logic ls_drives(input seq_state_e s);
        return (s == ST_LS_ON) || (s == ST_LS_FALL);
    endfunction

endpackage

// File: rtl/gdrv_pwm_decode.sv
module gdrv_pwm_decode
    import gdrv_pkg::*;
#(
    parameter int TRI_HOLD = 60
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     above_hi,
    input  logic     below_lo,
    input  logic     in_mid,
    output pwm_cmd_e cmd
);
    localparam int MW = $clog2(TRI_HOLD + 1);

    pwm_cmd_e       cmd_q;
    logic [MW-1:0]  mid_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_PARK;
            mid_cnt <= '0;
        end else if (above_hi) begin
            cmd_q   <= CMD_HI;
            mid_cnt <= '0;
        end else if (below_lo) begin
            cmd_q   <= CMD_LO;
            mid_cnt <= '0;
        end else if (in_mid) begin
            if (mid_cnt == MW'(TRI_HOLD - 1)) begin
                cmd_q <= CMD_PARK;
            end else begin
                mid_cnt <= mid_cnt + MW'(1);
            end
        end else begin
            mid_cnt <= '0;
        end
    end

    assign cmd = cmd_q;
endmodule

// File: rtl/gdrv_en_filter.sv
module gdrv_en_filter #(
    parameter int DIS_DLY = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic dis_n,
    output logic en_ok
);
    localparam int DW = $clog2(DIS_DLY + 1);

    logic          en_q;
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            cnt  <= '0;
        end else if (dis_n != en_q) begin
            if (cnt == DW'(DIS_DLY - 1)) begin
                en_q <= dis_n;
                cnt  <= '0;
            end else begin
                cnt <= cnt + DW'(1);
            end
        end else begin
            cnt <= '0;
        end
    end

    assign en_ok = en_q;
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
    import gdrv_pkg::*;
#(
    parameter int HS_ON_DLY  = 4,
    parameter int HS_OFF_DLY = 5,
    parameter int LS_ON_DLY  = 5,
    parameter int LS_OFF_DLY = 3,
    parameter int MAX_WAIT   = 32,
    parameter int CNT_W      = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  pwm_cmd_e   cmd,
    input  logic       boot_uv,
    input  logic       sw_low,
    input  logic       hsg_low,
    input  logic       skip_n,
    output logic       gh_en,
    output logic       gl_en,
    output seq_state_e state
);
    seq_state_e       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             gh_q, gl_q;
    logic             hs_ok;

    assign hs_ok = (cmd == CMD_HI) && !boot_uv;

    always_comb begin
        st_n  = st;
        cnt_n = '0;
        if (!go) begin
            st_n = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF: begin
                    if (hs_ok)               st_n = ST_HS_DLY;
                    else if (cmd == CMD_LO)  st_n = ST_LS_DLY;
                end
                ST_HS_DLY: begin
                    if (!hs_ok)                               st_n = ST_OFF;
                    else if (cnt == CNT_W'(HS_ON_DLY - 1))    st_n = ST_HS_ON;
                    else                                      cnt_n = cnt + CNT_W'(1);
                end
                ST_HS_ON: begin
                    if (cmd != CMD_HI) st_n = ST_HS_FALL;
                end
                ST_HS_FALL: begin
                    if (cmd == CMD_HI)                        st_n = ST_HS_ON;
                    else if (cnt == CNT_W'(HS_OFF_DLY - 1))   st_n = (cmd == CMD_LO) ? ST_SENSE : ST_OFF;
                    else                                      cnt_n = cnt + CNT_W'(1);
                end
                ST_SENSE: begin
                    if (cmd == CMD_HI)                        st_n = boot_uv ? ST_OFF : ST_HS_DLY;
                    else if (cmd == CMD_PARK)                 st_n = ST_OFF;
                    else if (sw_low || hsg_low)               st_n = ST_LS_DLY;
                    else if (cnt == CNT_W'(MAX_WAIT - 1))     st_n = ST_STALL;
                    else                                      cnt_n = cnt + CNT_W'(1);
                end
                ST_LS_DLY: begin
                    if (cmd == CMD_HI)                        st_n = boot_uv ? ST_OFF : ST_HS_DLY;
                    else if (cmd == CMD_PARK)                 st_n = ST_OFF;
                    else if (cnt == CNT_W'(LS_ON_DLY - 1))    st_n = ST_LS_ON;
                    else                                      cnt_n = cnt + CNT_W'(1);
                end
                ST_LS_ON: begin
                    if (cmd != CMD_LO) st_n = ST_LS_FALL;
                end
                ST_LS_FALL: begin
                    if (cmd == CMD_LO)                        st_n = ST_LS_ON;
                    else if (cnt == CNT_W'(LS_OFF_DLY - 1))   st_n = hs_ok ? ST_HS_DLY : ST_OFF;
                    else                                      cnt_n = cnt + CNT_W'(1);
                end
                ST_STALL: begin
                    if (hs_ok)                   st_n = ST_HS_DLY;
                    else if (cmd == CMD_PARK)    st_n = ST_OFF;
                end
                default: st_n = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_OFF;
            cnt  <= '0;
            gh_q <= 1'b0;
            gl_q <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            gh_q <= hs_drives(st_n);
            gl_q <= ls_drives(st_n) && skip_n;
        end
    end

    assign gh_en = gh_q;
    assign gl_en = gl_q;
    assign state = st;
endmodule

// File: rtl/gate_dt_ctrl.sv
module gate_dt_ctrl
    import gdrv_pkg::*;
#(
    parameter int HS_ON_DLY  = 4,
    parameter int HS_OFF_DLY = 5,
    parameter int LS_ON_DLY  = 5,
    parameter int LS_OFF_DLY = 3,
    parameter int TRI_HOLD   = 60,
    parameter int DIS_DLY    = 5,
    parameter int MAX_WAIT   = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwm_above_hi,
    input  logic       pwm_below_lo,
    input  logic       pwm_in_mid,
    input  logic       dis_n,
    input  logic       skip_n,
    input  logic       bias_uv,
    input  logic       boot_uv,
    input  logic       sw_low,
    input  logic       hsg_low,
    output logic       gh_en,
    output logic       gl_en,
    output logic [3:0] state_o,
    output logic       timeout_o
);
    localparam int MAX_DLY = max2(max2(max2(HS_ON_DLY, HS_OFF_DLY),
                                       max2(LS_ON_DLY, LS_OFF_DLY)), MAX_WAIT);
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    pwm_cmd_e   cmd;
    logic       en_ok;
    logic       go;
    seq_state_e st;

    gdrv_pwm_decode #(.TRI_HOLD(TRI_HOLD)) dec_i (
        .clk      (clk),
        .rst      (rst),
        .above_hi (pwm_above_hi),
        .below_lo (pwm_below_lo),
        .in_mid   (pwm_in_mid),
        .cmd      (cmd)
    );

    gdrv_en_filter #(.DIS_DLY(DIS_DLY)) enf_i (
        .clk   (clk),
        .rst   (rst),
        .dis_n (dis_n),
        .en_ok (en_ok)
    );

    assign go = en_ok && !bias_uv;

    gdrv_seq #(
        .HS_ON_DLY  (HS_ON_DLY),
        .HS_OFF_DLY (HS_OFF_DLY),
        .LS_ON_DLY  (LS_ON_DLY),
        .LS_OFF_DLY (LS_OFF_DLY),
        .MAX_WAIT   (MAX_WAIT),
        .CNT_W      (CNT_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .cmd     (cmd),
        .boot_uv (boot_uv),
        .sw_low  (sw_low),
        .hsg_low (hsg_low),
        .skip_n  (skip_n),
        .gh_en   (gh_en),
        .gl_en   (gl_en),
        .state   (st)
    );

    assign state_o   = st;
    assign timeout_o = (st == ST_STALL);
endmodule

// File: rtl/gdrv_sva.sv
module gdrv_sva (
    input logic clk,
    input logic rst,
    input logic bias_uv,
    input logic boot_uv,
    input logic skip_n,
    input logic gh_en,
    input logic gl_en,
    input logic timeout_o
);
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(gh_en && gl_en));

    assert_gl_after_gh_off_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gl_en) |-> !$past(gh_en));

    assert_gh_after_gl_off_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gh_en) |-> !$past(gl_en));

    assert_skip_masks_low_R7: assert property (@(posedge clk) disable iff (rst)
        !skip_n |=> !gl_en);

    assert_bias_uv_off_R8: assert property (@(posedge clk) disable iff (rst)
        bias_uv |=> (!gh_en && !gl_en));

    assert_boot_blocks_hs_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(gh_en) |-> !$past(boot_uv));

    assert_stall_low_off_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !gl_en);
endmodule

bind gate_dt_ctrl gdrv_sva sva_i (
    .clk       (clk),
    .rst       (rst),
    .bias_uv   (bias_uv),
    .boot_uv   (boot_uv),
    .skip_n    (skip_n),
    .gh_en     (gh_en),
    .gl_en     (gl_en),
    .timeout_o (timeout_o)
);

// File: tb/gate_dt_ctrl_tb_top.sv
`timescale 1ns/1ps
module gate_dt_ctrl_tb_top;
    localparam int HSON  = 4;
    localparam int HSOFF = 5;
    localparam int LSON  = 5;
    localparam int LSOFF = 3;
    localparam int TRI   = 60;
    localparam int DISD  = 5;
    localparam int MAXW  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_above_hi = 1'b0, pwm_below_lo = 1'b0, pwm_in_mid = 1'b1;
    logic dis_n = 1'b1, skip_n = 1'b1, bias_uv = 1'b0, boot_uv = 1'b0;
    logic sw_low = 1'b0, hsg_low = 1'b0;
    logic gh_en, gl_en, timeout_o;
    logic [3:0] state_o;

    int checks = 0;
    int errors = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gate_dt_ctrl #(
        .HS_ON_DLY(HSON), .HS_OFF_DLY(HSOFF), .LS_ON_DLY(LSON), .LS_OFF_DLY(LSOFF),
        .TRI_HOLD(TRI), .DIS_DLY(DISD), .MAX_WAIT(MAXW)
    ) dut_i (
        .clk(clk), .rst(rst), .pwm_above_hi(pwm_above_hi), .pwm_below_lo(pwm_below_lo),
        .pwm_in_mid(pwm_in_mid), .dis_n(dis_n), .skip_n(skip_n), .bias_uv(bias_uv),
        .boot_uv(boot_uv), .sw_low(sw_low), .hsg_low(hsg_low), .gh_en(gh_en),
        .gl_en(gl_en), .state_o(state_o), .timeout_o(timeout_o)
    );

    always @(negedge clk) if (!rst && gh_en && gl_en) overlap++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pwm(input int m);
        @(negedge clk);
        pwm_above_hi = (m == 1);
        pwm_below_lo = (m == 0);
        pwm_in_mid   = (m == 2);
    endtask

    task automatic wait_for(input int sel, input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (((sel == 0) ? gh_en : gl_en) != val && n < 500);
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic t_reset;
        idle(1);
        chk("R11 reset state", int'(state_o), 0);
        chk("R11 reset gh", int'(gh_en), 0);
        chk("R11 reset gl", int'(gl_en), 0);
        @(negedge clk) rst = 1'b0;
        idle(DISD + 4);
        chk("R5 parked after reset", int'(state_o), 0);
    endtask

    task automatic t_hs_on;
        int n;
        set_pwm(1);
        wait_for(0, 1'b1, n);
        chk("R1 hs on latency", n, HSON + 2);
        chk("R1 gl off", int'(gl_en), 0);
        chk("R11 hs on code", int'(state_o), 2);
    endtask

    task automatic t_adaptive_sw;
        int n;
        sw_low = 1'b1; hsg_low = 1'b0;
        set_pwm(0);
        wait_for(0, 1'b0, n);
        chk("R2 hs off latency", n, HSOFF + 2);
        wait_for(1, 1'b1, n);
        chk("R2 ls on after sense", n, LSON + 1);
        chk("R11 ls on code", int'(state_o), 6);
    endtask

    task automatic t_ls_to_hs;
        int n;
        set_pwm(1);
        wait_for(1, 1'b0, n);
        chk("R1 ls off latency", n, LSOFF + 2);
        wait_for(0, 1'b1, n);
        chk("R1 hs on after ls off", n, HSON);
    endtask

    task automatic t_backup;
        sw_low = 1'b0; hsg_low = 1'b1;
        set_pwm(0);
        idle(HSOFF + LSON + 8);
        chk("R3 gate-discharge path ls on", int'(gl_en), 1);
        hsg_low = 1'b0;
    endtask

    task automatic t_timeout;
        sw_low = 1'b0; hsg_low = 1'b0;
        set_pwm(1);
        idle(20);
        set_pwm(0);
        idle(HSOFF + MAXW + 6);
        chk("R10 timeout flag", int'(timeout_o), 1);
        chk("R10 stall code", int'(state_o), 8);
        chk("R10 ls held off", int'(gl_en), 0);
        hsg_low = 1'b1;
        idle(10);
        chk("R10 late flag ignored", int'(gl_en), 0);
        hsg_low = 1'b0;
        set_pwm(1);
        idle(HSON + 4);
        chk("R10 hs resumes", int'(gh_en), 1);
        chk("R10 timeout cleared", int'(timeout_o), 0);
    endtask

    task automatic t_tristate;
        int n;
        int dropped = 0;
        set_pwm(2);
        repeat (TRI - 4) begin
            @(negedge clk);
            if (!gh_en) dropped++;
        end
        set_pwm(1);
        idle(3);
        chk("R5 short mid ignored", dropped, 0);
        chk("R5 short mid gh", int'(gh_en), 1);
        set_pwm(2);
        idle(TRI + HSOFF + 10);
        chk("R5 park gh", int'(gh_en), 0);
        chk("R5 park gl", int'(gl_en), 0);
        chk("R5 park code", int'(state_o), 0);
        sw_low = 1'b1;
        set_pwm(0);
        wait_for(1, 1'b1, n);
        chk("R5 exit to low side", n, LSON + 2);
    endtask

    task automatic t_skip;
        @(negedge clk) skip_n = 1'b0;
        idle(2);
        chk("R7 skip masks gl", int'(gl_en), 0);
        chk("R7 state continues", int'(state_o), 6);
        set_pwm(1);
        idle(LSOFF + HSON + 4);
        chk("R7 hs still operates", int'(gh_en), 1);
        set_pwm(0);
        idle(HSOFF + LSON + 8);
        chk("R7 gl held off", int'(gl_en), 0);
        @(negedge clk) skip_n = 1'b1;
        idle(1);
        chk("R7 gl released", int'(gl_en), 1);
    endtask

    task automatic t_disable;
        int n;
        int dropped = 0;
        set_pwm(1);
        idle(LSOFF + HSON + 4);
        @(negedge clk) dis_n = 1'b0;
        repeat (DISD - 2) @(negedge clk);
        dis_n = 1'b1;
        repeat (DISD + 3) begin
            @(negedge clk);
            if (!gh_en) dropped++;
        end
        chk("R6 short disable ignored", dropped, 0);
        @(negedge clk) dis_n = 1'b0;
        wait_for(0, 1'b0, n);
        chk("R6 disable latency", n, DISD + 1);
        idle(20);
        chk("R6 held off", int'(gh_en), 0);
        @(negedge clk) dis_n = 1'b1;
        wait_for(0, 1'b1, n);
        chk("R6 enable latency", n, DISD + 1 + HSON);
    endtask

    task automatic t_bias;
        int n;
        @(negedge clk) bias_uv = 1'b1;
        idle(1);
        chk("R8 uv gh off", int'(gh_en), 0);
        chk("R8 uv code", int'(state_o), 0);
        idle(5);
        @(negedge clk) bias_uv = 1'b0;
        wait_for(0, 1'b1, n);
        chk("R8 restart latency", n, HSON + 1);
    endtask

    task automatic t_boot;
        int n;
        sw_low = 1'b1;
        set_pwm(0);
        idle(HSOFF + LSON + 8);
        @(negedge clk) boot_uv = 1'b1;
        set_pwm(1);
        idle(LSOFF + HSON + 10);
        chk("R9 hs blocked", int'(gh_en), 0);
        chk("R9 ls released", int'(gl_en), 0);
        chk("R9 off code", int'(state_o), 0);
        @(negedge clk) boot_uv = 1'b0;
        wait_for(0, 1'b1, n);
        chk("R9 hs after boot ok", n, HSON + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        t_reset();
        t_hs_on();
        t_adaptive_sw();
        t_ls_to_hs();
        t_backup();
        t_timeout();
        t_tristate();
        t_skip();
        t_disable();
        t_bias();
        t_boot();
        chk("R4 overlap cycles", overlap, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule